// File: doc/BRIEF.md
# Segmented Effective Address Generator

This unit forms the address of a memory operand for a 16-bit machine with segmented memory. Each cycle it takes the four pointer-capable registers (two bases, two indexes), the four segment registers, an addressing-mode code, a displacement with its size, and an optional segment-override request. One clock later it presents the 16-bit offset, the 16-bit segment that was chosen, and the 20-bit physical address made from them.

The offset is a base, an index, a base plus index, or a direct displacement, with an optional 8-bit or 16-bit constant added. The stack base selects the stack segment by default. Every other mode selects the data segment. An override replaces that default. Mode codes or displacement-size codes outside the supported set raise an illegal flag and force all three address outputs to zero. The unit does no instruction decoding and runs no bus cycles.

Top module: `seg_ea_gen`

## Requirements
- R1: While `rst_n` is low, `ea_offset`, `ea_segment`, `phys_addr` and `mode_bad` are all zero.
- R2: The outputs are registered. Inputs sampled at a rising clock edge appear on the outputs right after that edge and hold until the next edge.
- R3: The paired modes are `mode` 0 = bx+si, 1 = bx+di, 2 = bp+si and 3 = bp+di. The offset is the sum of the two registers plus the displacement.
- R4: The single-register modes are `mode` 4 = si, 5 = di, 6 = bp and 7 = bx. The offset is that register plus the displacement.
- R5: `disp_kind` sets the displacement for modes 0 to 7. A value of 0 adds zero and ignores `disp`. A value of 1 adds `disp[7:0]` sign-extended to 16 bits. A value of 2 adds all 16 bits of `disp`.
- R6: Mode 8 is direct. The offset equals `disp` whatever the value of `disp_kind`, and the default segment is the data segment.
- R7: With no override, modes 2, 3 and 6 select `seg_ss`. All other legal modes select `seg_ds`.
- R8: When `ovr_en` is 1, `ovr_sel` picks the segment in place of the default: 0 = `seg_es`, 1 = `seg_cs`, 2 = `seg_ss`, 3 = `seg_ds`.
- R9: The offset sum wraps modulo 2^16. No carry from it reaches the segment or the physical address beyond `segment*16 + offset`.
- R10: `phys_addr` equals `ea_segment` times 16 plus `ea_offset`, truncated to 20 bits.
- R11: Any `mode` of 9 to 15, or `disp_kind` = 3 with a mode of 0 to 7, sets `mode_bad` to 1 and drives offset, segment and physical address to zero. Every other combination clears `mode_bad`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_bx | input | 16 | Base register, data side |
| reg_bp | input | 16 | Base register, stack side |
| reg_si | input | 16 | Index register |
| reg_di | input | 16 | Index register |
| seg_es | input | 16 | Extra segment value |
| seg_cs | input | 16 | Code segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_ds | input | 16 | Data segment value |
| mode | input | 4 | Addressing-mode code (see R3, R4, R6, R11) |
| disp_kind | input | 2 | Displacement size code (see R5) |
| disp | input | 16 | Displacement value |
| ovr_en | input | 1 | Segment override request |
| ovr_sel | input | 2 | Override segment code (see R8) |
| ea_offset | output | 16 | Effective offset |
| ea_segment | output | 16 | Selected segment value |
| phys_addr | output | 20 | Physical address |
| mode_bad | output | 1 | Illegal mode or displacement-size code |

## Verification
The bench targets these corner cases:

- **Offset wrap.** A register sum that passes 0xFFFF checks R9. A design that kept the carry would move the physical address up by 64 KiB.
- **Physical-address wrap.** Segment 0xFFFF with a large offset must wrap past 20 bits to a low physical address.
- **Sign extension.** The 8-bit displacement 0x80 must become 0xFF80. Zero-extending it would move the operand forward instead of back.
- **Default segment.** The stack-base modes must select the stack segment unless an override is asserted. Both sides of that choice are driven under random register values.
- **Illegal codes.** Illegal mode and size codes must report `mode_bad` and zeroed outputs. A design that still decoded them would leak a valid-looking address.

// File: rtl/seg_ea_gen.sv
module seg_ea_gen #(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [OFS_W-1:0]           reg_bx,
  input  logic [OFS_W-1:0]           reg_bp,
  input  logic [OFS_W-1:0]           reg_si,
  input  logic [OFS_W-1:0]           reg_di,
  input  logic [OFS_W-1:0]           seg_es,
  input  logic [OFS_W-1:0]           seg_cs,
  input  logic [OFS_W-1:0]           seg_ss,
  input  logic [OFS_W-1:0]           seg_ds,
  input  logic [3:0]                 mode,
  input  logic [1:0]                 disp_kind,
  input  logic [OFS_W-1:0]           disp,
  input  logic                       ovr_en,
  input  logic [1:0]                 ovr_sel,
  output logic [OFS_W-1:0]           ea_offset,
  output logic [OFS_W-1:0]           ea_segment,
  output logic [OFS_W+SEG_SHIFT-1:0] phys_addr,
  output logic                       mode_bad
);
  localparam int PA_W = OFS_W + SEG_SHIFT;

  logic [OFS_W-1:0] base_v, index_v, disp_v, off_n, seg_n;
  logic [PA_W-1:0]  phys_n;
  logic             stack_based, direct, bad_n;

  always_comb begin
    base_v      = '0;
    index_v     = '0;
    stack_based = 1'b0;
    direct      = 1'b0;
    bad_n       = 1'b0;
    case (mode)
      4'd0: begin base_v = reg_bx; index_v = reg_si; end
      4'd1: begin base_v = reg_bx; index_v = reg_di; end
      4'd2: begin base_v = reg_bp; index_v = reg_si; stack_based = 1'b1; end
      4'd3: begin base_v = reg_bp; index_v = reg_di; stack_based = 1'b1; end
      4'd4: index_v = reg_si;
      4'd5: index_v = reg_di;
      4'd6: begin base_v = reg_bp; stack_based = 1'b1; end
      4'd7: base_v = reg_bx;
      4'd8: direct = 1'b1;
      default: bad_n = 1'b1;
    endcase
    if (!direct && disp_kind == 2'd3) bad_n = 1'b1;
  end

  always_comb begin
    case (disp_kind)
      2'd1:    disp_v = {{(OFS_W-8){disp[7]}}, disp[7:0]};
      2'd2:    disp_v = disp;
      default: disp_v = '0;
    endcase
  end

  always_comb begin
    if (ovr_en) begin
      case (ovr_sel)
        2'd0:    seg_n = seg_es;
        2'd1:    seg_n = seg_cs;
        2'd2:    seg_n = seg_ss;
        default: seg_n = seg_ds;
      endcase
    end else begin
      seg_n = stack_based ? seg_ss : seg_ds;
    end
  end

  assign off_n  = direct ? disp : base_v + index_v + disp_v;
  assign phys_n = ({{SEG_SHIFT{1'b0}}, seg_n} << SEG_SHIFT) + {{SEG_SHIFT{1'b0}}, off_n};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea_offset  <= '0;
      ea_segment <= '0;
      phys_addr  <= '0;
      mode_bad   <= 1'b0;
    end else begin
      mode_bad   <= bad_n;
      ea_offset  <= bad_n ? '0 : off_n;
      ea_segment <= bad_n ? '0 : seg_n;
      phys_addr  <= bad_n ? '0 : phys_n;
    end
  end

  assert_phys_sum_R10: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr == PA_W'(({{SEG_SHIFT{1'b0}}, ea_segment} << SEG_SHIFT) + {{SEG_SHIFT{1'b0}}, ea_offset}));

  assert_bad_zeroes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_bad |-> (ea_offset == '0 && ea_segment == '0 && phys_addr == '0));

  assert_illegal_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode > 4'd8) |=> mode_bad);

  assert_direct_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd8) |=> (!mode_bad && ea_offset == $past(disp)));

  assert_stack_default_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_en && disp_kind != 2'd3 && (mode == 4'd2 || mode == 4'd3 || mode == 4'd6))
      |=> (ea_segment == $past(seg_ss)));

  assert_override_es_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_en && ovr_sel == 2'd0 && mode <= 4'd8 && (mode == 4'd8 || disp_kind != 2'd3))
      |=> (ea_segment == $past(seg_es)));
endmodule

// File: tb/seg_ea_gen_tb.sv
module seg_ea_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0;
  logic [15:0] seg_es = '0, seg_cs = '0, seg_ss = '0, seg_ds = '0;
  logic [3:0]  mode = '0;
  logic [1:0]  disp_kind = '0;
  logic [15:0] disp = '0;
  logic        ovr_en = 1'b0;
  logic [1:0]  ovr_sel = '0;
  logic [15:0] ea_offset, ea_segment;
  logic [19:0] phys_addr;
  logic        mode_bad;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seg_ea_gen u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .mode(mode), .disp_kind(disp_kind), .disp(disp),
    .ovr_en(ovr_en), .ovr_sel(ovr_sel),
    .ea_offset(ea_offset), .ea_segment(ea_segment),
    .phys_addr(phys_addr), .mode_bad(mode_bad)
  );

  function automatic bit exp_bad();
    if (mode > 4'd8) return 1'b1;
    if (mode != 4'd8 && disp_kind == 2'd3) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [15:0] exp_off();
    logic [15:0] d;
    logic [15:0] r;
    if (exp_bad()) return 16'h0;
    if (mode == 4'd8) return disp;
    d = (disp_kind == 2'd1) ? {{8{disp[7]}}, disp[7:0]} : (disp_kind == 2'd2) ? disp : 16'h0;
    case (mode)
      4'd0: r = reg_bx + reg_si;
      4'd1: r = reg_bx + reg_di;
      4'd2: r = reg_bp + reg_si;
      4'd3: r = reg_bp + reg_di;
      4'd4: r = reg_si;
      4'd5: r = reg_di;
      4'd6: r = reg_bp;
      default: r = reg_bx;
    endcase
    return r + d;
  endfunction

  function automatic logic [15:0] exp_seg();
    if (exp_bad()) return 16'h0;
    if (ovr_en) begin
      case (ovr_sel)
        2'd0: return seg_es;
        2'd1: return seg_cs;
        2'd2: return seg_ss;
        default: return seg_ds;
      endcase
    end
    if (mode == 4'd2 || mode == 4'd3 || mode == 4'd6) return seg_ss;
    return seg_ds;
  endfunction

  function automatic logic [19:0] exp_phys();
    logic [19:0] p;
    if (exp_bad()) return 20'h0;
    p = {exp_seg(), 4'h0} + {4'h0, exp_off()};
    return p;
  endfunction

  task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic apply_and_check(input string tag);
    logic [15:0] eo, es;
    logic [19:0] ep;
    bit eb;
    eb = exp_bad(); eo = exp_off(); es = exp_seg(); ep = exp_phys();
    @(posedge clk);
    @(negedge clk);
    chk({tag, " bad R11"},   {19'h0, mode_bad}, {19'h0, eb});
    chk({tag, " off R3/R4"}, {4'h0, ea_offset}, {4'h0, eo});
    chk({tag, " seg R7/R8"}, {4'h0, ea_segment}, {4'h0, es});
    chk({tag, " phys R10"},  phys_addr, ep);
  endtask

  task automatic set_regs(input logic [15:0] bx, bp, si, di);
    reg_bx = bx; reg_bp = bp; reg_si = si; reg_di = di;
  endtask

  initial begin
    #200000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    seg_es = 16'h1000; seg_cs = 16'h2000; seg_ss = 16'h3000; seg_ds = 16'h4000;
    set_regs(16'h1111, 16'h2222, 16'h3333, 16'h4444);
    mode = 4'd0; disp_kind = 2'd2; disp = 16'h5555;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("reset R1 off",  {4'h0, ea_offset}, 20'h0);
    chk("reset R1 seg",  {4'h0, ea_segment}, 20'h0);
    chk("reset R1 phys", phys_addr, 20'h0);
    chk("reset R1 bad",  {19'h0, mode_bad}, 20'h0);
    rst_n = 1'b1;

    // R3 pairs
    disp_kind = 2'd0;
    for (int m = 0; m < 4; m++) begin mode = m[3:0]; apply_and_check("pair R3"); end
    // R4 singles with disp16
    disp_kind = 2'd2; disp = 16'h0102;
    for (int m = 4; m < 8; m++) begin mode = m[3:0]; apply_and_check("single R4"); end
    // R5 sign extension: disp8 0x80 -> FF80 from bx=0x0100 -> 0x0080
    set_regs(16'h0100, 16'h0, 16'h0, 16'h0);
    mode = 4'd7; disp_kind = 2'd1; disp = 16'hAB80;
    apply_and_check("disp8 R5");
    chk("disp8 R5 value", {4'h0, ea_offset}, 20'h00080);
    // R5 kind 0 ignores disp
    disp_kind = 2'd0; disp = 16'hFFFF;
    apply_and_check("nodisp R5");
    chk("nodisp R5 value", {4'h0, ea_offset}, 20'h00100);
    // R6 direct, disp_kind ignored, DS default
    mode = 4'd8; disp_kind = 2'd3; disp = 16'h0023;
    apply_and_check("direct R6");
    chk("direct R6 seg", {4'h0, ea_segment}, 20'h04000);
    // R7 stack default
    mode = 4'd6; disp_kind = 2'd0; reg_bp = 16'h0010;
    apply_and_check("stackdef R7");
    chk("stackdef R7 phys", phys_addr, 20'h30010);
    // R8 override each code
    ovr_en = 1'b1;
    for (int s = 0; s < 4; s++) begin ovr_sel = s[1:0]; apply_and_check("override R8"); end
    ovr_en = 1'b0;
    // R9 offset wrap
    set_regs(16'hFFFF, 16'h0, 16'h0002, 16'h0);
    mode = 4'd0; disp_kind = 2'd0;
    apply_and_check("wrap R9");
    chk("wrap R9 phys", phys_addr, 20'h40001);
    // R10 physical wrap past 20 bits
    seg_ds = 16'hFFFF; set_regs(16'h0, 16'h0, 16'h0010, 16'h0);
    mode = 4'd4;
    apply_and_check("physwrap R10");
    chk("physwrap R10 value", phys_addr, 20'h00000);
    // R11 illegal codes
    mode = 4'd12; apply_and_check("badmode R11");
    mode = 4'd1; disp_kind = 2'd3; apply_and_check("badkind R11");
    // R2: hold steady across an edge with unchanged inputs
    mode = 4'd5; disp_kind = 2'd2; disp = 16'h0007; reg_di = 16'h1000;
    apply_and_check("latency R2");
    @(posedge clk); @(negedge clk);
    chk("hold R2", {4'h0, ea_offset}, 20'h01007);

    // random
    for (int i = 0; i < 3000; i++) begin
      set_regs($urandom, $urandom, $urandom, $urandom);
      seg_es = $urandom; seg_cs = $urandom; seg_ss = $urandom; seg_ds = $urandom;
      mode = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(9, 15)) : 4'($urandom_range(0, 8));
      disp_kind = $urandom; disp = $urandom;
      ovr_en = ($urandom_range(0, 3) == 0); ovr_sel = $urandom;
      apply_and_check("random R3/R5/R7/R9");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule